// File: doc/BRIEF.md
# Streaming COO Sparse Matrix-Vector Compute Unit

This block is one compute lane of an iterative sparse matrix-vector product. The matrix arrives in coordinate form as wide 512-bit packets, each holding five non-zero triplets. For every triplet the unit issues a lookup into its own copy of the dense vector, so all five lookups leave in the same cycle. It multiplies each matrix value by the returned vector element and sums the products that share an output row. Finished row results are packed into 512-bit result words.

A run starts with a start pulse that carries the matrix base address and the packet count. The unit splits the fetch into bounded bursts and takes the returned packets over a valid/ready handshake. It drains its pipeline when the last packet has been taken, flushes the partial row and the partial word, and pulses `done`. The next run can use the results of the previous one as its dense vector. Because rows arrive sorted, one running accumulator carries a row's partial sum across packet boundaries.

Top module: `coo_spmv_unit`

## Requirements
- R1: After reset, and before any start, `in_ready`, `req_valid`, `out_valid` and `done` are all low.
- R2: Non-zero k (0..4) of a packet takes bits [96k+31:96k] as row index, [96k+63:96k+32] as column index and [96k+95:96k+64] as value. Bits [511:480] of the packet have no effect on any result.
- R3: In the cycle a packet is accepted, all five `vec_rd_en` bits are high and lane k drives the column index of non-zero k on `vec_rd_addr[32k+31:32k]`. Read data is taken two cycles later.
- R4: Values are signed fixed point with 1 sign bit and 31 fraction bits. Each product is the full product shifted right arithmetically by 31. Sums are kept at 40 bits and saturated to 0x7FFFFFFF or 0x80000000 on output.
- R5: Consecutive non-zeros with the same row index, whether inside one packet or across packet boundaries, are summed into one result.
- R6: A result word holds the row index of slot 0 in bits [511:480] and the value for row base+s in bits [32s+31:32s], s = 0..14. `out_mask[s]` marks each filled slot, and slot 0 is always filled. A row at or beyond base+15 closes the word and opens a new one based at that row. Words of a run leave with strictly rising bases, at most one word per cycle.
- R7: Once every packet has been accepted and processed, the pending row and any open word are emitted. `done` then pulses for exactly one cycle. A run of zero packets gives no words and still pulses `done`.
- R8: The fetch is split into bursts of at most 256 beats. Their beat counts sum to the packet count, and each burst's byte address advances by 64 per beat of the burst before it.
- R9: While result words do not congest the packer, one packet is accepted every cycle, so N back-to-back packets are accepted in N consecutive cycles.
- R10: A new start after `done` runs a fresh product with the current contents of the dense vector. No row state carries over from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while one is active) |
| cfg_base | input | 32 | Byte address of the first matrix packet |
| cfg_packets | input | 32 | Number of packets in the run |
| req_valid | output | 1 | Burst request present this cycle |
| req_addr | output | 32 | Burst byte address |
| req_beats | output | 9 | Burst length in packets (1..256) |
| in_valid | input | 1 | Matrix packet valid |
| in_ready | output | 1 | Unit accepts a packet this cycle |
| in_data | input | 512 | Matrix packet with five triplets |
| vec_rd_en | output | 5 | Per-lane dense-vector read enable |
| vec_rd_addr | output | 160 | Per-lane element index, 32 bits each |
| vec_rd_data | input | 160 | Per-lane element, two cycles after the request |
| out_valid | output | 1 | Result word valid |
| out_data | output | 512 | Packed result word |
| out_mask | output | 15 | Filled-slot mask of the result word |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A packet accepted at clock edge T drives its five lookups in the cycle before T. Its products are stored at edge T+2, and the earliest result word it can cause is registered at edge T+3. After the last packet leaves the pipeline, the flush takes two more edges and `done` rises on the second. The bench samples at falling edges only. It checks the lookup lanes in the same cycle a packet is accepted. Result words are compared in order against a model built from the requirements, so their exact cycle does not matter. It checks throughput by counting the cycles between the first and the last accepted packet.

// File: rtl/coo_spmv_pkg.sv
package coo_spmv_pkg;
  localparam int IDX_W   = 32;
  localparam int VAL_W   = 32;
  localparam int ACC_W   = 40;
  localparam int LANES   = 5;
  localparam int ENTRY_W = IDX_W + IDX_W + VAL_W;
  localparam int PKT_W   = 512;
  localparam int SLOTS   = 15;
  localparam int OUT_W   = SLOTS * VAL_W + IDX_W;

  typedef struct packed {
    logic [IDX_W-1:0]        row;
    logic signed [ACC_W-1:0] prod;
  } lane_prod_t;

  typedef lane_prod_t [LANES-1:0] pkt_prod_t;

  typedef struct packed {
    logic                   open;
    logic [IDX_W-1:0]       base;
    logic [SLOTS-1:0]       mask;
    logic [SLOTS*VAL_W-1:0] vals;
  } word_t;

  // Q1.31 times Q1.31, rescaled to Q.31 at accumulator width
  function automatic logic signed [ACC_W-1:0] fx_product(input logic [VAL_W-1:0] a,
                                                         input logic [VAL_W-1:0] b);
    logic signed [2*VAL_W-1:0] full;
    full = (2*VAL_W)'($signed(a)) * (2*VAL_W)'($signed(b));
    return ACC_W'(full >>> (VAL_W-1));
  endfunction

  // clamp an accumulator into the output value range
  function automatic logic [VAL_W-1:0] sat_val(input logic signed [ACC_W-1:0] acc);
    if ((&acc[ACC_W-1:VAL_W-1]) || !(|acc[ACC_W-1:VAL_W-1])) return acc[VAL_W-1:0];
    else if (acc[ACC_W-1]) return {1'b1, {(VAL_W-1){1'b0}}};
    else return {1'b0, {(VAL_W-1){1'b1}}};
  endfunction

  function automatic logic fits(input word_t w, input logic [IDX_W-1:0] row);
    return w.open && ((row - w.base) < IDX_W'(SLOTS));
  endfunction

  function automatic word_t place(input word_t w, input logic [IDX_W-1:0] row,
                                  input logic [VAL_W-1:0] val);
    word_t            r;
    logic [IDX_W-1:0] off;
    r   = w;
    off = row - w.base;
    for (int k = 0; k < SLOTS; k++) begin
      if (off == IDX_W'(k)) begin
        r.vals[k*VAL_W +: VAL_W] = val;
        r.mask[k] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic word_t fresh(input logic [IDX_W-1:0] row, input logic [VAL_W-1:0] val);
    word_t w;
    w      = '0;
    w.open = 1'b1;
    w.base = row;
    return place(w, row, val);
  endfunction
endpackage

// File: rtl/coo_burst_issuer.sv
module coo_burst_issuer
  import coo_spmv_pkg::*;
#(
  parameter int MAX_BURST  = 256,
  parameter int BEAT_BYTES = 64,
  localparam int BEATS_W   = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   cfg_base,
  input  logic [IDX_W-1:0]   cfg_packets,
  input  logic               accept,
  input  logic               finish,
  output logic               req_valid,
  output logic [IDX_W-1:0]   req_addr,
  output logic [BEATS_W-1:0] req_beats,
  output logic               accepting,
  output logic               all_in
);
  logic             running;
  logic [IDX_W-1:0] rem_req, rem_rx, addr;

  assign req_valid = running && (rem_req != '0);
  assign req_addr  = addr;
  assign req_beats = (rem_req >= IDX_W'(MAX_BURST)) ? BEATS_W'(MAX_BURST) : BEATS_W'(rem_req);
  assign accepting = running && (rem_rx != '0);
  assign all_in    = running && (rem_rx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      rem_req <= '0;
      rem_rx  <= '0;
      addr    <= '0;
    end else if (start && !running) begin
      running <= 1'b1;
      rem_req <= cfg_packets;
      rem_rx  <= cfg_packets;
      addr    <= cfg_base;
    end else begin
      if (finish) running <= 1'b0;
      if (req_valid) begin
        rem_req <= rem_req - IDX_W'(req_beats);
        addr    <= addr + IDX_W'(req_beats) * IDX_W'(BEAT_BYTES);
      end
      if (accept) rem_rx <= rem_rx - 1'b1;
    end
  end

  p_burst_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0) && (req_beats <= BEATS_W'(MAX_BURST)));

  p_accept_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> running && (rem_rx != '0));
endmodule

// File: rtl/coo_lookup_pipe.sv
module coo_lookup_pipe
  import coo_spmv_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accepting,
  input  logic                   in_valid,
  input  logic [PKT_W-1:0]       in_data,
  output logic                   in_ready,
  output logic                   fire,
  output logic [LANES-1:0]       vec_rd_en,
  output logic [LANES*IDX_W-1:0] vec_rd_addr,
  input  logic [LANES*VAL_W-1:0] vec_rd_data,
  output logic                   head_valid,
  output pkt_prod_t              head,
  input  logic                   pop,
  output logic                   idle
);
  logic [IDX_W-1:0] in_row [LANES];
  logic [VAL_W-1:0] in_val [LANES];
  logic [IDX_W-1:0] s1_row [LANES], s2_row [LANES];
  logic [VAL_W-1:0] s1_val [LANES], s2_val [LANES];
  logic             s1_v, s2_v;
  pkt_prod_t        prod_pkt;
  logic             push;
  pkt_prod_t        fifo_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   load;
  logic             pad_unused;

  assign pad_unused = &{1'b0, in_data[PKT_W-1:LANES*ENTRY_W]};

  // credit: every packet in flight already owns a FIFO slot
  assign load     = {1'b0, cnt} + (CNT_W+1)'(s1_v) + (CNT_W+1)'(s2_v);
  assign in_ready = accepting && (load < (CNT_W+1)'(DEPTH));
  assign fire     = in_valid && in_ready;
  assign vec_rd_en = {LANES{fire}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign in_row[g] = in_data[g*ENTRY_W +: IDX_W];
    assign vec_rd_addr[g*IDX_W +: IDX_W] = in_data[g*ENTRY_W + IDX_W +: IDX_W];
    assign in_val[g] = in_data[g*ENTRY_W + 2*IDX_W +: VAL_W];
    assign prod_pkt[g].row  = s2_row[g];
    assign prod_pkt[g].prod = fx_product(s2_val[g], vec_rd_data[g*VAL_W +: VAL_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= fire;
      s2_v <= s1_v;
    end
    for (int i = 0; i < LANES; i++) begin
      s1_row[i] <= in_row[i];
      s1_val[i] <= in_val[i];
      s2_row[i] <= s1_row[i];
      s2_val[i] <= s1_val[i];
    end
  end

  assign push       = s2_v;
  assign head_valid = (cnt != '0);
  assign head       = fifo_mem[rd_ptr];
  assign idle       = !s1_v && !s2_v && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
    if (push) fifo_mem[wr_ptr] <= prod_pkt;
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CNT_W'(DEPTH)) || pop);

  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
endmodule

// File: rtl/coo_row_packer.sv
module coo_row_packer
  import coo_spmv_pkg::*;
#(
  localparam int PTR_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  pkt_prod_t        head,
  output logic             pop,
  input  logic             stream_end,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic [SLOTS-1:0] out_mask,
  output logic             done
);
  typedef enum logic [1:0] {PK_RUN, PK_FLUSH, PK_TAIL, PK_WAIT} pk_state_t;

  pk_state_t               state, n_state;
  logic [PTR_W-1:0]        ptr, n_ptr;
  logic                    acc_v, n_acc_v;
  logic [IDX_W-1:0]        acc_row, n_acc_row;
  logic signed [ACC_W-1:0] acc_sum, n_acc_sum;
  word_t                   word, n_word, e_word;
  logic                    emit, halt, n_done;

  always_comb begin
    n_state = state; n_ptr = ptr; n_acc_v = acc_v; n_acc_row = acc_row;
    n_acc_sum = acc_sum; n_word = word; e_word = '0; emit = 1'b0;
    halt = 1'b0; pop = 1'b0; n_done = 1'b0;
    case (state)
      PK_RUN: begin
        if (head_valid) begin
          for (int i = 0; i < LANES; i++) begin
            if (!halt && (PTR_W'(i) >= ptr)) begin
              if (n_acc_v && (head[i].row == n_acc_row)) begin
                n_acc_sum = n_acc_sum + head[i].prod;
              end else begin
                if (n_acc_v) begin
                  if (fits(n_word, n_acc_row)) begin
                    n_word = place(n_word, n_acc_row, sat_val(n_acc_sum));
                  end else if (n_word.open && emit) begin
                    halt = 1'b1;       // second word would leave: resume next cycle
                  end else begin
                    if (n_word.open) begin
                      emit = 1'b1;
                      e_word = n_word;
                    end
                    n_word = fresh(n_acc_row, sat_val(n_acc_sum));
                  end
                end
                if (!halt) begin
                  n_acc_v   = 1'b1;
                  n_acc_row = head[i].row;
                  n_acc_sum = head[i].prod;
                end
              end
              if (!halt) n_ptr = PTR_W'(i + 1);
            end
          end
          if (n_ptr == PTR_W'(LANES)) begin
            pop   = 1'b1;
            n_ptr = '0;
          end
        end else if (stream_end) begin
          n_state = PK_FLUSH;
        end
      end
      PK_FLUSH: begin
        if (acc_v) begin
          if (fits(word, acc_row)) begin
            n_word = place(word, acc_row, sat_val(acc_sum));
          end else begin
            if (word.open) begin
              emit = 1'b1;
              e_word = word;
            end
            n_word = fresh(acc_row, sat_val(acc_sum));
          end
        end
        n_acc_v = 1'b0;
        n_state = PK_TAIL;
      end
      PK_TAIL: begin
        if (word.open) begin
          emit = 1'b1;
          e_word = word;
        end
        n_word  = '0;
        n_done  = 1'b1;
        n_state = PK_WAIT;
      end
      default: begin
        if (!stream_end) n_state = PK_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PK_RUN; ptr <= '0; acc_v <= 1'b0; acc_row <= '0; acc_sum <= '0;
      word <= '0; out_valid <= 1'b0; out_data <= '0; out_mask <= '0; done <= 1'b0;
    end else begin
      state <= n_state; ptr <= n_ptr; acc_v <= n_acc_v; acc_row <= n_acc_row;
      acc_sum <= n_acc_sum; word <= n_word; done <= n_done;
      out_valid <= emit;
      if (emit) begin
        out_data <= {e_word.base, e_word.vals};
        out_mask <= e_word.mask;
      end
    end
  end

  // checker state: last base emitted in the current run
  logic             seen_word;
  logic [IDX_W-1:0] last_base;
  always_ff @(posedge clk) begin
    if (!rst_n || done) begin
      seen_word <= 1'b0;
      last_base <= '0;
    end else if (out_valid) begin
      seen_word <= 1'b1;
      last_base <= out_data[OUT_W-1 -: IDX_W];
    end
  end

  p_first_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask[0]);

  p_base_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_word) |-> (out_data[OUT_W-1 -: IDX_W] > last_base));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/coo_spmv_unit.sv
module coo_spmv_unit
  import coo_spmv_pkg::*;
#(
  parameter int MAX_BURST  = 256,
  parameter int BEAT_BYTES = 64,
  parameter int FIFO_DEPTH = 4,
  localparam int BEATS_W   = $clog2(MAX_BURST + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [IDX_W-1:0]       cfg_base,
  input  logic [IDX_W-1:0]       cfg_packets,
  output logic                   req_valid,
  output logic [IDX_W-1:0]       req_addr,
  output logic [BEATS_W-1:0]     req_beats,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PKT_W-1:0]       in_data,
  output logic [LANES-1:0]       vec_rd_en,
  output logic [LANES*IDX_W-1:0] vec_rd_addr,
  input  logic [LANES*VAL_W-1:0] vec_rd_data,
  output logic                   out_valid,
  output logic [OUT_W-1:0]       out_data,
  output logic [SLOTS-1:0]       out_mask,
  output logic                   done
);
  logic      accepting, all_in, fire, head_valid, pop, pipe_idle, stream_end;
  pkt_prod_t head;

  assign stream_end = all_in && pipe_idle;

  coo_burst_issuer #(.MAX_BURST(MAX_BURST), .BEAT_BYTES(BEAT_BYTES)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_packets(cfg_packets), .accept(fire), .finish(done),
    .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats),
    .accepting(accepting), .all_in(all_in));

  coo_lookup_pipe #(.DEPTH(FIFO_DEPTH)) u_lookup (
    .clk(clk), .rst_n(rst_n), .accepting(accepting), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .fire(fire), .vec_rd_en(vec_rd_en),
    .vec_rd_addr(vec_rd_addr), .vec_rd_data(vec_rd_data), .head_valid(head_valid),
    .head(head), .pop(pop), .idle(pipe_idle));

  coo_row_packer u_pack (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head(head), .pop(pop),
    .stream_end(stream_end), .out_valid(out_valid), .out_data(out_data),
    .out_mask(out_mask), .done(done));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !accepting |-> !in_ready && (vec_rd_en == '0));
endmodule

// File: tb/coo_spmv_unit_test.sv
module coo_spmv_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 300;
  localparam int NCASE = 8;
  // n packets, row step, non-zeros per row, seed, junk in upper bits
  localparam int CASES [NCASE][5] = '{
    '{6, 1, 1, 1, 0}, '{10, 1, 3, 2, 1}, '{8, 3, 2, 3, 0}, '{12, 20, 1, 4, 1},
    '{7, 1, 5, 5, 0}, '{9, 2, 7, 6, 1}, '{20, 16, 4, 7, 0}, '{40, 1, 1, 8, 1}};

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [31:0] cfg_base = 0, cfg_packets = 0;
  logic [511:0] in_data = '0;
  logic req_valid, in_ready, out_valid, done;
  logic [31:0] req_addr;
  logic [8:0] req_beats;
  logic [4:0] vec_rd_en;
  logic [159:0] vec_rd_addr, vec_rd_data;
  logic [511:0] out_data;
  logic [14:0] out_mask;

  coo_spmv_unit uut (.clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_packets(cfg_packets), .req_valid(req_valid), .req_addr(req_addr),
    .req_beats(req_beats), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .vec_rd_en(vec_rd_en), .vec_rd_addr(vec_rd_addr), .vec_rd_data(vec_rd_data),
    .out_valid(out_valid), .out_data(out_data), .out_mask(out_mask), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0, fires = 0, first_fire = 0, last_fire = 0;
  logic [511:0] pkts [MAXP];
  logic [31:0] vmem [64];
  logic [31:0] q1 [5], q2 [5];
  logic [511:0] got_d[$], exp_d[$];
  logic [14:0] got_m[$], exp_m[$];
  logic [31:0] rq_addr[$];
  int rq_beats[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // two-cycle dense-vector replicas
  always @(posedge clk) begin
    for (int k = 0; k < 5; k++) begin
      q1[k] <= vmem[vec_rd_addr[k*32 +: 6]];
      q2[k] <= q1[k];
    end
  end
  always_comb for (int k = 0; k < 5; k++) vec_rd_data[k*32 +: 32] = q2[k];

  // monitor at falling edges
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (in_valid && in_ready) begin
        bit ok;
        ok = (vec_rd_en == 5'h1F);
        for (int k = 0; k < 5; k++) if (vec_rd_addr[k*32 +: 32] != in_data[k*96+32 +: 32]) ok = 0;
        chk(ok, "R3", "lookup lanes on accept", {352'b0, vec_rd_addr}, {352'b0, in_data[159:0]});
        if (fires == 0) first_fire = cyc;
        last_fire = cyc;
        fires++;
      end
      if (out_valid) begin got_d.push_back(out_data); got_m.push_back(out_mask); end
      if (req_valid) begin rq_addr.push_back(req_addr); rq_beats.push_back(int'(req_beats)); end
      if (done) done_cnt++;
    end
  end

  function automatic logic [31:0] mix(input int a, input int b);
    return 32'(a * 32'h9E3779B1) ^ 32'(b * 32'h85EBCA6B) ^ 32'(a * b);
  endfunction

  task automatic gen(input int n, input int step, input int dup, input int seed, input int junk);
    for (int p = 0; p < n; p++) begin
      pkts[p] = '0;
      for (int k = 0; k < 5; k++) begin
        int e;
        e = p * 5 + k;
        pkts[p][k*96 +: 32]    = 32'((e / dup) * step);
        pkts[p][k*96+32 +: 32] = 32'((e * 7 + seed) % 64);
        pkts[p][k*96+64 +: 32] = mix(e + 1, seed);
      end
      if (junk != 0) pkts[p][511:480] = 32'hDEAD0000 ^ 32'(seed * 977 + p);
    end
    for (int i = 0; i < 64; i++) vmem[i] = mix(i + 3, seed + 11);
  endtask

  // reference model built from R4, R5 and R6
  bit m_open;
  logic [31:0] m_base;
  logic [511:0] m_d;
  logic [14:0] m_m;
  task automatic commit(input logic [31:0] r, input longint s);
    logic [31:0] sv;
    int off;
    if (s > 64'sd2147483647) sv = 32'h7FFFFFFF;
    else if (s < -64'sd2147483648) sv = 32'h80000000;
    else sv = 32'(s);
    if (!(m_open && (r - m_base) < 15)) begin
      if (m_open) begin exp_d.push_back(m_d); exp_m.push_back(m_m); end
      m_open = 1; m_base = r; m_d = '0; m_m = '0;
      m_d[511:480] = r;
    end
    off = int'(r - m_base);
    m_d[off*32 +: 32] = sv;
    m_m[off] = 1'b1;
  endtask

  task automatic build_expected(input int n);
    longint s = 0;
    logic [31:0] cur = 0;
    bit have = 0;
    exp_d.delete(); exp_m.delete(); m_open = 0;
    for (int p = 0; p < n; p++)
      for (int k = 0; k < 5; k++) begin
        logic [31:0] r, c, v;
        longint prod;
        r = pkts[p][k*96 +: 32]; c = pkts[p][k*96+32 +: 32]; v = pkts[p][k*96+64 +: 32];
        prod = (longint'($signed(v)) * longint'($signed(vmem[c[5:0]]))) >>> 31;
        if (have && r == cur) s += prod;
        else begin
          if (have) commit(cur, s);
          cur = r; s = prod; have = 1;
        end
      end
    if (have) commit(cur, s);
    if (m_open) begin exp_d.push_back(m_d); exp_m.push_back(m_m); end
  endtask

  task automatic run_stream(input int n, input logic [31:0] base, input string tag);
    int d0, wait_c, idx, beats;
    build_expected(n);
    got_d.delete(); got_m.delete(); rq_addr.delete(); rq_beats.delete();
    fires = 0; d0 = done_cnt;
    @(negedge clk); start = 1; cfg_base = base; cfg_packets = 32'(n);
    @(negedge clk); start = 0;
    idx = 0;
    while (idx < n) begin
      in_valid = 1; in_data = pkts[idx];
      #1;
      if (in_ready) idx++;
      @(negedge clk);
    end
    in_valid = 0; in_data = '0;
    wait_c = 0;
    while (done_cnt == d0 && wait_c < 3000) begin @(negedge clk); wait_c++; end
    repeat (5) @(negedge clk);
    chk(done_cnt == d0 + 1, "R7", {tag, " single done pulse"}, 512'(done_cnt - d0), 512'd1);
    chk(got_d.size() == exp_d.size(), "R7", {tag, " word count"}, 512'(got_d.size()), 512'(exp_d.size()));
    for (int w = 0; w < got_d.size() && w < exp_d.size(); w++) begin
      chk(got_d[w] == exp_d[w], "R5", {tag, " word data"}, got_d[w], exp_d[w]);
      chk(got_m[w] == exp_m[w], "R6", {tag, " word mask"}, 512'(got_m[w]), 512'(exp_m[w]));
    end
    beats = 0;
    foreach (rq_beats[i]) beats += rq_beats[i];
    chk(beats == n, "R8", {tag, " total burst beats"}, 512'(beats), 512'(n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!in_ready && !req_valid && !out_valid && !done, "R1", "idle outputs after reset",
        512'({in_ready, req_valid, out_valid, done}), 512'd0);

    // table of stimulus patterns (R2 junk bits, R5 row runs, R6 window breaks)
    for (int c = 0; c < NCASE; c++) begin
      gen(CASES[c][0], CASES[c][1], CASES[c][2], CASES[c][3], CASES[c][4]);
      run_stream(CASES[c][0], 32'h1000 * c, $sformatf("case%0d", c));
    end

    // R2: upper bits changed only, result must not move
    gen(10, 1, 3, 2, 0);
    run_stream(10, 0, "r2_clean");
    begin
      logic [511:0] ref0;
      ref0 = got_d.size() > 0 ? got_d[0] : '0;
      for (int p = 0; p < 10; p++) pkts[p][511:480] = 32'hFFFFFFFF;
      run_stream(10, 0, "r2_junk");
      chk(got_d.size() > 0 && got_d[0] == ref0, "R2", "upper bits ignored", got_d.size() > 0 ? got_d[0] : '0, ref0);
    end

    // R4: saturation at both ends
    for (int p = 0; p < 2; p++) begin
      pkts[p] = '0;
      for (int k = 0; k < 5; k++) begin
        pkts[p][k*96 +: 32] = 32'(p);
        pkts[p][k*96+32 +: 32] = 32'(p + 1);
        pkts[p][k*96+64 +: 32] = 32'h80000000;
      end
    end
    vmem[1] = 32'h80000000; vmem[2] = 32'h7FFFFFFF;
    run_stream(2, 0, "r4_sat");
    chk(got_d.size() == 1 && got_d[0][31:0] == 32'h7FFFFFFF, "R4", "positive clamp",
        512'(got_d.size() > 0 ? got_d[0][31:0] : 32'h0), 512'(32'h7FFFFFFF));
    chk(got_d.size() == 1 && got_d[0][63:32] == 32'h80000000, "R4", "negative clamp",
        512'(got_d.size() > 0 ? got_d[0][63:32] : 32'h0), 512'(32'h80000000));

    // R8 and R9: long dense stream split in two bursts at full rate
    gen(300, 1, 1, 9, 0);
    run_stream(300, 32'h4000_0000, "r8_long");
    chk(rq_beats.size() == 2 && rq_beats[0] == 256 && rq_beats[1] == 44, "R8", "burst split",
        512'(rq_beats.size()), 512'd2);
    chk(rq_addr.size() == 2 && rq_addr[0] == 32'h4000_0000 && rq_addr[1] == 32'h4000_4000, "R8",
        "burst addresses", 512'(rq_addr.size() > 1 ? rq_addr[1] : 32'h0), 512'(32'h4000_4000));
    chk(last_fire - first_fire == 299, "R9", "one packet per cycle",
        512'(last_fire - first_fire), 512'd299);

    // R7: empty run
    run_stream(0, 0, "r7_empty");
    chk(got_d.size() == 0, "R7", "no words for empty run", 512'(got_d.size()), 512'd0);

    // R10: second iteration uses the first result as the dense vector
    gen(6, 1, 1, 12, 0);
    run_stream(6, 0, "r10_iter1");
    foreach (got_d[w])
      for (int s = 0; s < 15; s++)
        if (got_m[w][s] && int'(got_d[w][511:480]) + s < 64)
          vmem[int'(got_d[w][511:480]) + s] = got_d[w][s*32 +: 32];
    run_stream(6, 0, "r10_iter2");
    chk(!in_ready && !out_valid, "R10", "idle after second run", 512'({in_ready, out_valid}), 512'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule